// File: doc/BRIEF.md
# Per-Sample DMA Request Arbiter for a Stereo Audio Codec

This block raises the data requests that pace DMA traffic between a host and the sample registers of a stereo audio codec. Each sample period it raises a playback request at the start of the period. If capture is enabled, it raises a capture request a fixed number of cycles later. Each request stays high until the host asserts the matching active-low acknowledge and finishes the sample with the required number of byte strobes. Write strobes carry playback bytes and read strobes carry capture bytes. A byte counter steers the data lane and finds the last strobe of each sample.

In single-channel mode both directions share the playback request and acknowledge pins. The capture pins then stay idle. When both enables are set, playback wins. If a sample tick comes while that direction's request is still pending, a sticky flag is set and no second request is queued.

Top module: `smp_dma_arb`

## Requirements
- R1: A direction raises a request only while its enable is 1 and its programmed-I/O select is 0. Otherwise its ticks produce no request.
- R2: In two-channel mode, `pb_req` goes high in the cycle after a cycle in which `smp_tick` is 1.
- R3: The capture request goes high CAP_DLY+1 cycles after the tick cycle, which is CAP_DLY cycles after the playback request (CAP_DLY defaults to 8).
- R4: A request stays high while its acknowledge is high. Strobes seen while the acknowledge is high are not counted.
- R5: While acknowledged, each falling edge of the accepted strobe advances `byte_lane` by one. `bytes_sel` encodes the sample length: 0 means 1 byte, 1 means 2 bytes, 2 or 3 means 4 bytes. The request drops in the cycle after the falling edge of the last byte, and `byte_lane` returns to 0.
- R6: Playback counts only `wr_n` edges and capture counts only `rd_n` edges. Edges on the other strobe change neither `byte_lane` nor the request.
- R7: Clearing an enable bit does not drop a request that is already high. The request is still serviced normally.
- R8: With `single_ch` set, capture requests appear on `pb_req` and are acknowledged on `pb_ack_n`. `cap_req` stays low and `cap_ack_n` has no effect.
- R9: With `single_ch` set and both enables set, the shared channel works as playback: it is raised by the tick and counts write strobes.
- R10: A tick that arrives while the request for its direction is still high sets a sticky flag (`pb_urun` for playback, `cap_orun` for capture) and does not queue another request.
- R11: While `rst_n` is low, all requests, flags, counters and `byte_lane` are 0.
- R12: `xfer_wr` is 1 while a playback request is acknowledged. `xfer_rd` is 1 while a capture request is acknowledged on either pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_tick | input | 1 | One-cycle pulse at the start of each sample period |
| pb_en | input | 1 | Playback enable |
| pb_pio | input | 1 | Playback uses programmed I/O (1) instead of DMA |
| cap_en | input | 1 | Capture enable |
| cap_pio | input | 1 | Capture uses programmed I/O (1) instead of DMA |
| single_ch | input | 1 | Route capture over the playback handshake |
| bytes_sel | input | 2 | Bytes per sample: 0→1, 1→2, 2/3→4 |
| pb_ack_n | input | 1 | Playback acknowledge, active low |
| cap_ack_n | input | 1 | Capture acknowledge, active low |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| pb_req | output | 1 | Playback (or shared) data request |
| cap_req | output | 1 | Capture data request |
| byte_lane | output | 2 | Index of the byte being moved |
| xfer_wr | output | 1 | Acknowledged playback transfer in progress |
| xfer_rd | output | 1 | Acknowledged capture transfer in progress |
| pb_urun | output | 1 | Sticky playback underrun flag |
| cap_orun | output | 1 | Sticky capture overrun flag |

## Verification
Two functions can fall in the same cycle. A new sample tick can arrive while the previous request is still pending, so raising a request and detecting a repeat collide. In single-channel mode, playback priority and capture routing collide on one request register. The bench provokes the first by sending two ticks with no service in between. It then checks that the underrun flag sets and stays set, and that a single one-byte service leaves no request behind. For the second, the bench sets both enables in single-channel mode. It judges the outcome by the cycle in which `pb_req` rises and by which strobe type clears it.

// File: rtl/smp_dma_pkg.sv
package smp_dma_pkg;
  localparam int unsigned MAX_BYTES = 4;
  localparam int unsigned IDX_W     = $clog2(MAX_BYTES);
  typedef logic [IDX_W-1:0] idx_t;

  // index of the final byte of a sample for a given length code
  function automatic idx_t last_index(input logic [1:0] sel);
    case (sel)
      2'd0:    last_index = idx_t'(0);
      2'd1:    last_index = idx_t'(1);
      default: last_index = idx_t'(MAX_BYTES - 1);
    endcase
  endfunction
endpackage

// File: rtl/smp_phase_gen.sv
module smp_phase_gen #(
  parameter int unsigned CAP_DLY = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  output logic late_o
);
  localparam int unsigned DW = $clog2(CAP_DLY + 1);

  logic [DW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (tick_i) begin
      cnt_d  = DW'(CAP_DLY);
      cnt_en = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign late_o = (cnt_q == DW'(1));
endmodule

// File: rtl/strobe_fall_det.sv
module strobe_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_n_i,
  input  logic wr_n_i,
  output logic rd_fall_o,
  output logic wr_fall_o
);
  logic rd_prev_q, wr_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_prev_q <= 1'b1;
      wr_prev_q <= 1'b1;
    end else begin
      rd_prev_q <= rd_n_i;
      wr_prev_q <= wr_n_i;
    end
  end

  assign rd_fall_o = rd_prev_q & ~rd_n_i;
  assign wr_fall_o = wr_prev_q & ~wr_n_i;
endmodule

// File: rtl/smp_dma_chan.sv
module smp_dma_chan
  import smp_dma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic raise_i,
  input  logic ack_n_i,
  input  logic strb_fall_i,
  input  idx_t last_i,
  output logic req_o,
  output idx_t lane_o,
  output logic xrun_o
);
  logic req_q, req_d;
  idx_t cnt_q, cnt_d;
  logic adv, reg_en;

  assign adv = req_q & ~ack_n_i & strb_fall_i;

  always_comb begin
    req_d  = req_q;
    cnt_d  = cnt_q;
    reg_en = 1'b0;
    if (adv) begin
      reg_en = 1'b1;
      if (cnt_q == last_i) begin
        req_d = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    if (raise_i && !req_q) begin
      req_d  = 1'b1;
      reg_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      cnt_q <= '0;
    end else if (reg_en) begin
      req_q <= req_d;
      cnt_q <= cnt_d;
    end
  end

  assign req_o  = req_q;
  assign lane_o = cnt_q;
  assign xrun_o = raise_i & req_q;
endmodule

// File: rtl/smp_dma_arb.sv
module smp_dma_arb
  import smp_dma_pkg::*;
#(
  parameter int unsigned CAP_DLY = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       smp_tick,
  input  logic       pb_en,
  input  logic       pb_pio,
  input  logic       cap_en,
  input  logic       cap_pio,
  input  logic       single_ch,
  input  logic [1:0] bytes_sel,
  input  logic       pb_ack_n,
  input  logic       cap_ack_n,
  input  logic       rd_n,
  input  logic       wr_n,
  output logic       pb_req,
  output logic       cap_req,
  output logic [1:0] byte_lane,
  output logic       xfer_wr,
  output logic       xfer_rd,
  output logic       pb_urun,
  output logic       cap_orun
);
  logic pb_on, cap_on, late, rd_fall, wr_fall;
  logic a_sel_cap, a_raise, a_fall, a_req, a_xrun;
  logic b_raise, b_ack_n, b_req, b_xrun;
  logic a_cap_q, a_cap_d, a_cap_en;
  logic urun_q, urun_d, orun_q, orun_d;
  idx_t a_lane, b_lane, last;

  assign pb_on  = pb_en & ~pb_pio;
  assign cap_on = cap_en & ~cap_pio;
  assign last   = last_index(bytes_sel);

  smp_phase_gen #(.CAP_DLY(CAP_DLY)) u_phase (
    .clk(clk), .rst_n(rst_n), .tick_i(smp_tick), .late_o(late)
  );

  strobe_fall_det u_edge (
    .clk(clk), .rst_n(rst_n), .rd_n_i(rd_n), .wr_n_i(wr_n),
    .rd_fall_o(rd_fall), .wr_fall_o(wr_fall)
  );

  // shared channel: capture only when single mode and playback enable clear
  assign a_sel_cap = single_ch & ~pb_en & cap_on;
  assign a_raise   = a_sel_cap ? late : (pb_on & smp_tick);
  assign a_cap_en  = a_raise & ~a_req;
  assign a_cap_d   = a_sel_cap;
  assign a_fall    = a_cap_q ? rd_fall : wr_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        a_cap_q <= 1'b0;
    else if (a_cap_en) a_cap_q <= a_cap_d;
  end

  smp_dma_chan u_chan_a (
    .clk(clk), .rst_n(rst_n), .raise_i(a_raise), .ack_n_i(pb_ack_n),
    .strb_fall_i(a_fall), .last_i(last), .req_o(a_req), .lane_o(a_lane),
    .xrun_o(a_xrun)
  );

  assign b_raise = ~single_ch & cap_on & late;
  assign b_ack_n = cap_ack_n | single_ch;

  smp_dma_chan u_chan_b (
    .clk(clk), .rst_n(rst_n), .raise_i(b_raise), .ack_n_i(b_ack_n),
    .strb_fall_i(rd_fall), .last_i(last), .req_o(b_req), .lane_o(b_lane),
    .xrun_o(b_xrun)
  );

  always_comb begin
    urun_d = urun_q | (a_xrun & ~a_sel_cap);
    orun_d = orun_q | b_xrun | (a_xrun & a_sel_cap);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      urun_q <= 1'b0;
      orun_q <= 1'b0;
    end else begin
      urun_q <= urun_d;
      orun_q <= orun_d;
    end
  end

  assign pb_req    = a_req;
  assign cap_req   = b_req;
  assign byte_lane = (a_req & ~pb_ack_n) ? a_lane : b_lane;
  assign xfer_wr   = a_req & ~pb_ack_n & ~a_cap_q;
  assign xfer_rd   = (a_req & ~pb_ack_n & a_cap_q) | (b_req & ~b_ack_n);
  assign pb_urun   = urun_q;
  assign cap_orun  = orun_q;
endmodule

// File: rtl/smp_dma_arb_chk.sv
module smp_dma_arb_chk (
  input logic clk,
  input logic rst_n,
  input logic pb_en,
  input logic pb_pio,
  input logic cap_en,
  input logic cap_pio,
  input logic single_ch,
  input logic pb_ack_n,
  input logic cap_ack_n,
  input logic pb_req,
  input logic cap_req,
  input logic pb_urun,
  input logic cap_orun
);
  // R1: a rising request traces back to an enabled DMA direction
  assert_pb_rise_enabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pb_req) |-> $past((pb_en && !pb_pio) || (single_ch && cap_en && !cap_pio)));
  assert_cap_rise_enabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_req) |-> $past(cap_en && !cap_pio && !single_ch));
  // R4: without acknowledge a request is held
  assert_pb_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pb_req && pb_ack_n |=> pb_req);
  assert_cap_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_req && cap_ack_n |=> cap_req);
  // R8: capture pin stays idle in single-channel mode
  assert_cap_idle_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    single_ch && !cap_req |=> !cap_req);
  // R10: flags are sticky
  assert_urun_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pb_urun |=> pb_urun);
  assert_orun_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cap_orun |=> cap_orun);
endmodule

bind smp_dma_arb smp_dma_arb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pb_en(pb_en), .pb_pio(pb_pio),
  .cap_en(cap_en), .cap_pio(cap_pio), .single_ch(single_ch),
  .pb_ack_n(pb_ack_n), .cap_ack_n(cap_ack_n), .pb_req(pb_req),
  .cap_req(cap_req), .pb_urun(pb_urun), .cap_orun(cap_orun)
);

// File: tb/smp_dma_arb_tb.sv
module smp_dma_arb_tb;
  localparam int unsigned DLY = 8;

  logic clk = 1'b0;
  logic rst_n, smp_tick, pb_en, pb_pio, cap_en, cap_pio, single_ch;
  logic [1:0] bytes_sel;
  logic pb_ack_n, cap_ack_n, rd_n, wr_n;
  logic pb_req, cap_req, xfer_wr, xfer_rd, pb_urun, cap_orun;
  logic [1:0] byte_lane;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  smp_dma_arb #(.CAP_DLY(DLY)) u_dut (
    .clk(clk), .rst_n(rst_n), .smp_tick(smp_tick), .pb_en(pb_en),
    .pb_pio(pb_pio), .cap_en(cap_en), .cap_pio(cap_pio),
    .single_ch(single_ch), .bytes_sel(bytes_sel), .pb_ack_n(pb_ack_n),
    .cap_ack_n(cap_ack_n), .rd_n(rd_n), .wr_n(wr_n), .pb_req(pb_req),
    .cap_req(cap_req), .byte_lane(byte_lane), .xfer_wr(xfer_wr),
    .xfer_rd(xfer_rd), .pb_urun(pb_urun), .cap_orun(cap_orun)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; smp_tick = 1'b0; pb_en = 1'b0; pb_pio = 1'b0;
    cap_en = 1'b0; cap_pio = 1'b0; single_ch = 1'b0; bytes_sel = 2'd0;
    pb_ack_n = 1'b1; cap_ack_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic tick();
    smp_tick = 1'b1;
    step(1);
    smp_tick = 1'b0;
  endtask

  task automatic strobe(input bit is_rd);
    if (is_rd) rd_n = 1'b0; else wr_n = 1'b0;
    step(1);
    rd_n = 1'b1; wr_n = 1'b1;
    step(1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    step(1);
    chk("R11 pb_req", pb_req, 0);
    chk("R11 cap_req", cap_req, 0);
    chk("R11 lane", byte_lane, 0);
    chk("R11 flags", {pb_urun, cap_orun}, 0);
    do_reset();
  endtask

  task automatic t_playback();
    do_reset();
    pb_en = 1'b1; bytes_sel = 2'd1;
    chk("R2 pb_req before tick", pb_req, 0);
    tick();
    chk("R2 pb_req after tick", pb_req, 1);
    strobe(1'b0);
    chk("R4 held without ack", pb_req, 1);
    pb_ack_n = 1'b0;
    step(1);
    chk("R5 lane start", byte_lane, 0);
    chk("R12 xfer_wr", xfer_wr, 1);
    chk("R12 xfer_rd idle", xfer_rd, 0);
    strobe(1'b0);
    chk("R5 first byte keeps req", pb_req, 1);
    chk("R5 lane advanced", byte_lane, 1);
    strobe(1'b1);
    chk("R6 read strobe ignored lane", byte_lane, 1);
    chk("R6 read strobe ignored req", pb_req, 1);
    wr_n = 1'b0;
    step(1);
    chk("R5 drop after last byte", pb_req, 0);
    chk("R5 lane back to 0", byte_lane, 0);
    wr_n = 1'b1; pb_ack_n = 1'b1;
    step(1);
  endtask

  task automatic t_capture();
    do_reset();
    cap_en = 1'b1; bytes_sel = 2'd2;
    tick();
    step(DLY - 1);
    chk("R3 capture not yet", cap_req, 0);
    step(1);
    chk("R3 capture raised", cap_req, 1);
    cap_ack_n = 1'b0;
    step(1);
    chk("R12 xfer_rd", xfer_rd, 1);
    for (int i = 0; i < 3; i++) strobe(1'b1);
    chk("R5 capture after 3 of 4", cap_req, 1);
    chk("R5 capture lane 3", byte_lane, 3);
    strobe(1'b0);
    chk("R6 write ignored on capture", byte_lane, 3);
    strobe(1'b1);
    chk("R5 capture drop after 4", cap_req, 0);
    cap_ack_n = 1'b1;
    step(1);
  endtask

  task automatic t_gating();
    do_reset();
    pb_en = 1'b1; pb_pio = 1'b1; cap_en = 1'b1; cap_pio = 1'b1;
    tick();
    chk("R1 pio playback no req", pb_req, 0);
    step(DLY + 1);
    chk("R1 pio capture no req", cap_req, 0);
    pb_en = 1'b0; pb_pio = 1'b0;
    tick();
    chk("R1 disabled playback no req", pb_req, 0);
  endtask

  task automatic t_disable();
    do_reset();
    pb_en = 1'b1;
    tick();
    pb_en = 1'b0;
    step(3);
    chk("R7 req survives disable", pb_req, 1);
    pb_ack_n = 1'b0;
    strobe(1'b0);
    chk("R7 serviced after disable", pb_req, 0);
    pb_ack_n = 1'b1;
    tick();
    chk("R7 no new req", pb_req, 0);
  endtask

  task automatic t_xrun();
    do_reset();
    pb_en = 1'b1;
    tick();
    chk("R10 no flag first", pb_urun, 0);
    step(2);
    tick();
    chk("R10 underrun set", pb_urun, 1);
    pb_ack_n = 1'b0;
    strobe(1'b0);
    chk("R10 no queued request", pb_req, 0);
    chk("R10 flag sticky", pb_urun, 1);
    chk("R10 capture flag clear", cap_orun, 0);
    pb_ack_n = 1'b1;
  endtask

  task automatic t_single();
    do_reset();
    single_ch = 1'b1; cap_en = 1'b1;
    tick();
    chk("R8 no early shared req", pb_req, 0);
    step(DLY);
    chk("R8 capture on shared pin", pb_req, 1);
    chk("R8 capture pin idle", cap_req, 0);
    cap_ack_n = 1'b0;
    strobe(1'b1);
    chk("R8 capture ack ignored", pb_req, 1);
    cap_ack_n = 1'b1; pb_ack_n = 1'b0;
    step(1);
    chk("R12 shared xfer_rd", xfer_rd, 1);
    strobe(1'b0);
    chk("R8 write ignored on capture", pb_req, 1);
    strobe(1'b1);
    chk("R8 shared capture served", pb_req, 0);
    pb_ack_n = 1'b1;
    step(1);
  endtask

  task automatic t_priority();
    do_reset();
    single_ch = 1'b1; cap_en = 1'b1; pb_en = 1'b1;
    tick();
    chk("R9 playback presumed", pb_req, 1);
    pb_ack_n = 1'b0;
    step(1);
    chk("R9 xfer_wr", xfer_wr, 1);
    strobe(1'b1);
    chk("R9 read ignored", pb_req, 1);
    strobe(1'b0);
    chk("R9 write served", pb_req, 0);
    pb_ack_n = 1'b1;
    step(DLY);
    chk("R9 no capture request", cap_req, 0);
    chk("R9 shared stays low", pb_req, 0);
  endtask

  initial begin
    rst_n = 1'b0; smp_tick = 1'b0; pb_en = 1'b0; pb_pio = 1'b0;
    cap_en = 1'b0; cap_pio = 1'b0; single_ch = 1'b0; bytes_sel = 2'd0;
    pb_ack_n = 1'b1; cap_ack_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_playback();
    t_capture();
    t_gating();
    t_disable();
    t_xrun();
    t_single();
    t_priority();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      if (done) break;
      @(posedge clk);
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hung expected done");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule